// File: doc/BRIEF.md
# Shared-Pool Virtual Channel Buffer Manager

This block keeps the books for one router input port whose flit buffer is a single shared pool. No virtual channel owns a fixed region of that pool. A packet's head flit is given a free virtual channel when it arrives. Every flit, head, body or tail, is given a free pool slot when it arrives. Each virtual channel keeps an ordered list of the slots that hold its flits, so the router can read that channel's flits in the order they came in.

When a flit leaves, its slot goes back to the pool. When the last listed flit of a channel leaves, the channel itself is freed again. Free channels and free slots are each tracked in a bitmap, and the lowest free index is always the next one offered. An arrival that cannot be placed is refused with a stall, so the sender holds the flit and tries again. The flit storage, routing and switch allocation sit outside this block.

Top module: `ubvc_manager`

## Requirements
- R1: After reset, both bitmaps show every entry free: next_free_vc and next_free_slot are 0, vc_none and slot_none are 0, every vc_empty bit is 1, every head slot reads 0, and no vc_row_full bit is set.
- R2: Each tracker offers the lowest-numbered free index. When nothing is free, it raises its none flag and shows index 0.
- R3: An accepted arrival is written into the slot offered in that cycle (arr_slot equals next_free_slot). That slot is marked occupied from the next cycle on.
- R4: An accepted arrival with arr_new_pkt = 1 claims the offered free VC in the same cycle, and arr_vc_used reports that VC. An arrival with arr_new_pkt = 0 uses the VC on arr_vc.
- R5: Each VC's list keeps its slots in arrival order. head_slot (VC g in bits [g*SW +: SW]) shows the oldest slot still listed. A departure removes that oldest entry and returns its slot to the pool.
- R6: When a departure removes the only listed entry of a VC, and no arrival to that VC happens in the same cycle, the VC is released. From the next cycle on it shows vc_empty = 1 and is offered again.
- R7: A slot freed by a departure cannot be taken by an arrival in the same cycle. It can be offered from the next cycle.
- R8: An arrival is refused (arr_accept = 0, arr_stall = 1) when no slot is free. An arrival with arr_new_pkt = 1 is also refused when no VC is free. A refused arrival changes no state.
- R9: An arrival with arr_new_pkt = 0 is refused when its VC is empty. It is also refused when the last position of that VC's list (ROW_DEPTH entries) is filled, which vc_row_full shows. The list does not wrap around, so positions freed at its front become usable again only after the VC has drained.
- R10: A departure naming an empty VC is ignored. It frees no slot and no VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | A flit is offered for storage |
| arr_new_pkt | input | 1 | The offered flit starts a packet and needs a fresh VC |
| arr_vc | input | VW | VC carried by a body or tail flit |
| arr_accept | output | 1 | The offered flit is taken this cycle |
| arr_stall | output | 1 | The offered flit is refused this cycle |
| arr_vc_used | output | VW | VC the offered flit goes to |
| arr_slot | output | SW | Pool slot the offered flit is written to |
| dep_valid | input | 1 | The oldest flit of a VC leaves |
| dep_vc | input | VW | VC whose oldest flit leaves |
| next_free_vc | output | VW | Lowest free VC (0 when none) |
| vc_none | output | 1 | No VC is free |
| next_free_slot | output | SW | Lowest free slot (0 when none) |
| slot_none | output | 1 | No slot is free |
| head_slot_flat | output | NUM_VC*SW | Oldest listed slot per VC, 0 for an empty VC |
| vc_empty | output | NUM_VC | VC lists no flit and is free |
| vc_row_full | output | NUM_VC | Last list position of the VC is filled |

## Verification
The bench builds the block with two VCs, four pool slots and a list depth of three. These small values make every scarcity case reachable in a few cycles: the VC bitmap runs dry after two packets, the slot pool runs dry after four flits, and a single VC fills its list after three arrivals. One table walks through claims, same-cycle arrival and departure, VC release and each refusal cause, and the values expected after every step were worked out by hand. Directed steps then check the reset state, both at start-up and after a reset applied partway through the run.

// File: rtl/ubvc_pkg.sv
package ubvc_pkg;

    // Index width for a count of n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ubvc_free_list.sv
module ubvc_free_list #(
    parameter int N  = 8,
    parameter int IW = ubvc_pkg::idx_width(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_en,
    input  logic          give_en,
    input  logic [IW-1:0] give_idx,
    output logic [IW-1:0] avail_idx,
    output logic          none_left
);

    typedef struct packed {
        logic [N-1:0] bits;   // 1 = free, 0 = in use
    } fl_state_t;

    fl_state_t st_d, st_q;

    // Lowest free index wins.
    always_comb begin
        avail_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (st_q.bits[i]) avail_idx = IW'(i);
        end
        none_left = ~|st_q.bits;
    end

    always_comb begin
        st_d = st_q;
        if (take_en) st_d.bits[avail_idx] = 1'b0;
        if (give_en) st_d.bits[give_idx]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    // A take must find something free.
    p_take_has_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |-> !none_left);

    // A taken index reads as occupied afterwards.
    p_take_marks_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_en |=> !st_q.bits[$past(avail_idx)]);

    // Only an occupied index may be returned.
    p_give_was_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
        give_en |-> !st_q.bits[give_idx]);

endmodule

// File: rtl/ubvc_vc_row.sv
module ubvc_vc_row #(
    parameter int DEPTH = 4,
    parameter int SW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [SW-1:0] push_slot,
    input  logic          pop_en,
    output logic [SW-1:0] head_slot,
    output logic          row_empty,
    output logic          row_full,
    output logic          row_release
);

    typedef struct packed {
        logic          nul;
        logic [SW-1:0] slot;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } row_state_t;

    row_state_t st_d, st_q;

    int oldest, youngest, used, push_pos;

    // Arrival and departure positions derived from the live entries.
    always_comb begin
        oldest   = 0;
        youngest = 0;
        used     = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.ent[i].nul) oldest = i;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!st_q.ent[i].nul) begin
                youngest = i;
                used     = used + 1;
            end
        end
        push_pos    = (used == 0) ? 0 : youngest + 1;
        row_empty   = (used == 0);
        row_full    = !st_q.ent[DEPTH-1].nul;
        head_slot   = row_empty ? '0 : st_q.ent[oldest].slot;
        row_release = pop_en && (used == 1) && !push_en;
    end

    always_comb begin
        st_d = st_q;
        if (pop_en && !row_empty) st_d.ent[oldest].nul = 1'b1;
        if (push_en && push_pos < DEPTH) begin
            st_d.ent[push_pos].nul  = 1'b0;
            st_d.ent[push_pos].slot = push_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.ent[i] <= '{nul: 1'b1, slot: '0};
            end
        end else begin
            st_q <= st_d;
        end
    end

    // A released row holds nothing afterwards.
    p_release_leaves_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_release |=> row_empty);

    // No write into a row whose last position is taken.
    p_full_blocks_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        row_full |-> !push_en);

    // A departure from a row with two or more flits leaves it non-empty.
    p_pop_keeps_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !row_release && !row_empty) |=> !row_empty);

endmodule

// File: rtl/ubvc_manager.sv
module ubvc_manager #(
    parameter int NUM_VC    = 4,
    parameter int NUM_SLOT  = 16,
    parameter int ROW_DEPTH = 4,
    localparam int VW = ubvc_pkg::idx_width(NUM_VC),
    localparam int SW = ubvc_pkg::idx_width(NUM_SLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arr_valid,
    input  logic                 arr_new_pkt,
    input  logic [VW-1:0]        arr_vc,
    output logic                 arr_accept,
    output logic                 arr_stall,
    output logic [VW-1:0]        arr_vc_used,
    output logic [SW-1:0]        arr_slot,
    input  logic                 dep_valid,
    input  logic [VW-1:0]        dep_vc,
    output logic [VW-1:0]        next_free_vc,
    output logic                 vc_none,
    output logic [SW-1:0]        next_free_slot,
    output logic                 slot_none,
    output logic [NUM_VC*SW-1:0] head_slot_flat,
    output logic [NUM_VC-1:0]    vc_empty,
    output logic [NUM_VC-1:0]    vc_row_full
);

    logic [NUM_VC-1:0] row_push, row_pop, row_rel;
    logic [SW-1:0]     head_arr [NUM_VC];
    logic              dep_fire, vc_give;
    logic [VW-1:0]     vc_give_idx;
    logic [SW-1:0]     slot_give_idx;

    // Admission of the offered flit.
    always_comb begin
        arr_vc_used = arr_new_pkt ? next_free_vc : arr_vc;
        arr_slot    = next_free_slot;
        if (!arr_valid || slot_none)
            arr_accept = 1'b0;
        else if (arr_new_pkt)
            arr_accept = !vc_none;
        else
            arr_accept = !vc_empty[arr_vc] && !vc_row_full[arr_vc];
        arr_stall = arr_valid && !arr_accept;
    end

    // Departure and release bookkeeping.
    always_comb begin
        dep_fire      = dep_valid && !vc_empty[dep_vc];
        slot_give_idx = head_arr[dep_vc];
        vc_give       = |row_rel;
        vc_give_idx   = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            if (row_rel[i]) vc_give_idx = VW'(i);
        end
    end

    ubvc_free_list #(.N(NUM_VC), .IW(VW)) u_vc_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_en   (arr_accept && arr_new_pkt),
        .give_en   (vc_give),
        .give_idx  (vc_give_idx),
        .avail_idx (next_free_vc),
        .none_left (vc_none)
    );

    ubvc_free_list #(.N(NUM_SLOT), .IW(SW)) u_slot_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_en   (arr_accept),
        .give_en   (dep_fire),
        .give_idx  (slot_give_idx),
        .avail_idx (next_free_slot),
        .none_left (slot_none)
    );

    for (genvar g = 0; g < NUM_VC; g++) begin : g_row
        assign row_push[g] = arr_accept && (arr_vc_used == VW'(g));
        assign row_pop[g]  = dep_fire && (dep_vc == VW'(g));

        ubvc_vc_row #(.DEPTH(ROW_DEPTH), .SW(SW)) u_row (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_en     (row_push[g]),
            .push_slot   (arr_slot),
            .pop_en      (row_pop[g]),
            .head_slot   (head_arr[g]),
            .row_empty   (vc_empty[g]),
            .row_full    (vc_row_full[g]),
            .row_release (row_rel[g])
        );

        assign head_slot_flat[g*SW +: SW] = head_arr[g];
    end

    // A refused flit whenever the pool is dry.
    p_stall_on_dry_pool_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && slot_none) |-> arr_stall);

    // The slot freed this cycle is never the one written this cycle.
    p_fresh_slot_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_fire && arr_accept) |-> (arr_slot != slot_give_idx));

    // A newly claimed VC holds the head flit afterwards.
    p_new_vc_claimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_accept && arr_new_pkt) |=> !vc_empty[$past(arr_vc_used)]);

    // A departure to an empty VC with no arrival leaves the pool unchanged.
    p_empty_dep_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_valid && vc_empty[dep_vc] && !arr_valid) |=> $stable(next_free_slot));

endmodule

// File: tb/ubvc_manager_bench.sv
module ubvc_manager_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 2;
    localparam int NS = 4;
    localparam int ND = 3;

    typedef struct packed {
        logic       av, nw, avc, dv, dvc;
        logic       acc, uvc;
        logic [1:0] uslot;
        logic       nvc, vnone;
        logic [1:0] nslot;
        logic       snone;
        logic [1:0] h0, h1, emp;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1,1,0,0,0, 1,0,2'd0, 1,0,2'd1,0, 2'd0,2'd0,2'b10},
        '{1,0,0,0,0, 1,0,2'd1, 1,0,2'd2,0, 2'd0,2'd0,2'b10},
        '{1,1,0,0,0, 1,1,2'd2, 0,1,2'd3,0, 2'd0,2'd2,2'b00},
        '{1,1,0,0,0, 0,0,2'd3, 0,1,2'd3,0, 2'd0,2'd2,2'b00},
        '{1,0,0,1,0, 1,0,2'd3, 0,1,2'd0,0, 2'd1,2'd2,2'b00},
        '{1,0,0,0,0, 0,0,2'd0, 0,1,2'd0,0, 2'd1,2'd2,2'b00},
        '{0,0,0,1,1, 0,0,2'd0, 1,0,2'd0,0, 2'd1,2'd0,2'b10},
        '{1,0,1,0,0, 0,1,2'd0, 1,0,2'd0,0, 2'd1,2'd0,2'b10},
        '{0,0,0,1,0, 0,0,2'd0, 1,0,2'd0,0, 2'd3,2'd0,2'b10},
        '{1,1,0,0,0, 1,1,2'd0, 0,1,2'd1,0, 2'd3,2'd0,2'b00},
        '{1,1,0,1,0, 0,0,2'd1, 0,0,2'd1,0, 2'd0,2'd0,2'b01},
        '{0,0,0,1,0, 0,0,2'd0, 0,0,2'd1,0, 2'd0,2'd0,2'b01},
        '{1,1,0,0,0, 1,0,2'd1, 0,1,2'd2,0, 2'd1,2'd0,2'b00},
        '{1,0,0,0,0, 1,0,2'd2, 0,1,2'd3,0, 2'd1,2'd0,2'b00},
        '{1,0,1,0,0, 1,1,2'd3, 0,1,2'd0,1, 2'd1,2'd0,2'b00},
        '{1,0,1,0,0, 0,1,2'd0, 0,1,2'd0,1, 2'd1,2'd0,2'b00}
    };

    localparam string TAGS [NVEC] = '{
        "R3", "R4", "R2", "R8", "R7", "R9", "R6", "R9",
        "R5", "R4", "R8", "R10", "R2", "R3", "R2", "R8"
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arr_valid = 1'b0, arr_new_pkt = 1'b0, dep_valid = 1'b0;
    logic [0:0] arr_vc = '0, dep_vc = '0;
    logic       arr_accept, arr_stall, vc_none, slot_none;
    logic [0:0] arr_vc_used, next_free_vc;
    logic [1:0] arr_slot, next_free_slot;
    logic [3:0] head_slot_flat;
    logic [1:0] vc_empty, vc_row_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ubvc_manager #(.NUM_VC(NV), .NUM_SLOT(NS), .ROW_DEPTH(ND)) u_ubvc_manager (
        .clk(clk), .rst_n(rst_n),
        .arr_valid(arr_valid), .arr_new_pkt(arr_new_pkt), .arr_vc(arr_vc),
        .arr_accept(arr_accept), .arr_stall(arr_stall),
        .arr_vc_used(arr_vc_used), .arr_slot(arr_slot),
        .dep_valid(dep_valid), .dep_vc(dep_vc),
        .next_free_vc(next_free_vc), .vc_none(vc_none),
        .next_free_slot(next_free_slot), .slot_none(slot_none),
        .head_slot_flat(head_slot_flat), .vc_empty(vc_empty),
        .vc_row_full(vc_row_full)
    );

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_reset_state();
        check("R1", "next_free_vc", int'(next_free_vc), 0);
        check("R1", "next_free_slot", int'(next_free_slot), 0);
        check("R1", "vc_none", int'(vc_none), 0);
        check("R1", "slot_none", int'(slot_none), 0);
        check("R1", "vc_empty", int'(vc_empty), 3);
        check("R1", "head_slot_flat", int'(head_slot_flat), 0);
        check("R1", "vc_row_full", int'(vc_row_full), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check_reset_state();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check_reset_state();

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            arr_valid   = VECS[i].av;
            arr_new_pkt = VECS[i].nw;
            arr_vc      = VECS[i].avc;
            dep_valid   = VECS[i].dv;
            dep_vc      = VECS[i].dvc;
            #1;
            check(TAGS[i], "arr_accept", int'(arr_accept), int'(VECS[i].acc));
            check(TAGS[i], "arr_stall", int'(arr_stall),
                  int'(VECS[i].av && !VECS[i].acc));
            if (VECS[i].acc) begin
                check(TAGS[i], "arr_vc_used", int'(arr_vc_used), int'(VECS[i].uvc));
                check(TAGS[i], "arr_slot", int'(arr_slot), int'(VECS[i].uslot));
            end
            @(posedge clk);
            #1;
            arr_valid = 1'b0;
            dep_valid = 1'b0;
            check(TAGS[i], "next_free_vc", int'(next_free_vc), int'(VECS[i].nvc));
            check(TAGS[i], "vc_none", int'(vc_none), int'(VECS[i].vnone));
            check(TAGS[i], "next_free_slot", int'(next_free_slot), int'(VECS[i].nslot));
            check(TAGS[i], "slot_none", int'(slot_none), int'(VECS[i].snone));
            check(TAGS[i], "head vc0", int'(head_slot_flat[1:0]), int'(VECS[i].h0));
            check(TAGS[i], "head vc1", int'(head_slot_flat[3:2]), int'(VECS[i].h1));
            check(TAGS[i], "vc_empty", int'(vc_empty), int'(VECS[i].emp));
        end

        // R9: list of VC0 full after three arrivals into a fresh VC.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check_reset_state();
        @(negedge clk) rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            arr_valid = 1'b1;
            arr_new_pkt = (k == 0);
            arr_vc = '0;
            @(posedge clk);
            #1 arr_valid = 1'b0;
        end
        check("R9", "vc_row_full after three", int'(vc_row_full), 1);
        @(negedge clk);
        arr_valid = 1'b1; arr_new_pkt = 1'b0; arr_vc = '0;
        #1 check("R9", "stall on full row", int'(arr_stall), 1);
        @(posedge clk);
        #1 arr_valid = 1'b0;
        check("R9", "slot not taken", int'(next_free_slot), 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule